// File: doc/BRIEF.md
# Half-Duplex MII Transmit Deferral Controller

This block decides when a 10/100 Ethernet port may put a frame onto a 4-bit MII transmit path. The decision depends on three things: a frame is waiting in the transmit buffer, the interframe spacing has elapsed, and the PHY reports no carrier. A frame starts only when all three hold. It then streams nibbles from a show-ahead buffer onto the transmit pins, one per nibble clock, and issues one read strobe for each nibble it takes.

Two programmable lengths govern the idle time between frames. Both are given in bit times and converted to nibble-clock cycles by dividing by four. The gap length sets the minimum idle time after the port's own transmission. The blinder length sets a window right after that transmission in which carrier sense is not looked at. Carrier seen outside the window restarts the gap count.

When the PHY flags a collision during a frame, the port stops taking data and sends a fixed 32-bit jam instead. It then pulses a retry request, which tells the buffer to rewind and tells an external backoff counter to start. The port then waits for that counter to report expiry. A per-frame collision counter gives up on the sixteenth collision and pulses an excessive-collision flag instead of asking for a retry. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `mii_tx_defer`

## Requirements
- R1: While reset is asserted, and for as long as no frame is pending afterwards, tx_en_o is 0, txd_o is 0, buf_rd_o is 0, and retry_o, done_o and excess_col_o are 0.
- R2: Between the fall of tx_en_o and its next rise there are at least ipg_len_i/4 cycles with tx_en_o low. With a frame waiting and no carrier, there are exactly that many. Shorter and longer settings than 96 bit times apply the same way.
- R3: A transmission starts only in a cycle where frame_avail_i is 1, the gap has elapsed and carrier sense is inactive or blinded. With frame_avail_i at 0, the block never raises tx_en_o or buf_rd_o.
- R4: crs_i is ignored during the first blind_len_i/4 cycles after tx_en_o falls. Carrier seen after that window restarts the gap count, so the next start comes ipg_len_i/4 cycles after the last carrier cycle.
- R5: tx_en_o rises in the same cycle as the first nibble. Nibbles appear in buffer order, one per cycle. buf_rd_o is high for exactly one cycle per nibble, in the cycle before that nibble is on txd_o. tx_en_o falls right after the nibble flagged by buf_last_i.
- R6: If col_i is 1 in a cycle where a frame nibble is on txd_o, the next 8 cycles carry the jam nibble 4'h5 with tx_en_o high. No further buffer reads occur, and tx_en_o then falls.
- R7: After a jam, retry_o pulses for one cycle, in the first cycle with tx_en_o low. Nothing is sent until backoff_done_i is seen. The frame is then retried from its first nibble under the normal deferral rules.
- R8: On the 16th collision of one frame, excess_col_o pulses after the jam in place of retry_o, and no backoff wait follows.
- R9: done_o pulses in the first cycle after a collision-free frame ends. Completion or abort clears the collision count, so a later frame again gets 16 attempts.
- R10: col_i has no effect outside frame data, whether idle or waiting for backoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock (transmit clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_avail_i | input | 1 | A frame is waiting in the transmit buffer |
| buf_nib_i | input | 4 | Current nibble at the buffer head |
| buf_last_i | input | 1 | Current buffer nibble is the frame's last |
| buf_rd_o | output | 1 | Pop the current buffer nibble |
| crs_i | input | 1 | Carrier sense from the PHY |
| col_i | input | 1 | Collision from the PHY |
| blind_len_i | input | 10 | Carrier-blind window in bit times |
| ipg_len_i | input | 10 | Minimum interframe gap in bit times |
| backoff_done_i | input | 1 | External backoff counter has expired |
| txd_o | output | 4 | Transmit nibble to the PHY |
| tx_en_o | output | 1 | Transmit enable to the PHY |
| retry_o | output | 1 | One-cycle pulse: rewind buffer, start backoff |
| done_o | output | 1 | One-cycle pulse: frame sent without collision |
| excess_col_o | output | 1 | One-cycle pulse: frame dropped after 16 collisions |

## Verification
The bench measures the exact idle run between frames at three gap settings. A gap counter that is off by one would give 23 or 25 cycles where 24 are expected. It places a carrier burst first inside the blinder window and then after it. A design that honoured carrier during the blinder, or failed to restart the count afterwards, would give a gap other than 24 or 38 respectively. It collides in the middle of a frame and checks the jam length, the read count and the rewound restart. This catches an extra buffer read, a jam one nibble short or long, and a retry that resumes mid-frame. It drives sixteen collisions on one frame to catch a counter that gives up one attempt early or late, or does not clear for the next frame.

// File: rtl/mii_defer_pkg.sv
package mii_defer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_JAM,
    ST_WAIT
  } tx_state_e;
endpackage

// File: rtl/mii_defer_timer.sv
module mii_defer_timer #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_active_i,
  input  logic             crs_i,
  input  logic [LEN_W-1:0] blind_len_i,
  input  logic [LEN_W-1:0] ipg_len_i,
  output logic             cts_o
);
  localparam int CYC_W = LEN_W - 2;
  localparam logic [CYC_W-1:0] CNT_MAX = '1;

  logic [CYC_W-1:0] since_q, since_d;
  logic [CYC_W-1:0] idle_q, idle_d;
  logic [CYC_W-1:0] blind_cyc, ipg_cyc;
  logic             blinded, crs_seen, gap_ok;

  always_comb begin
    blind_cyc = CYC_W'(blind_len_i >> 2);
    ipg_cyc   = CYC_W'(ipg_len_i >> 2);
    blinded   = (since_q < blind_cyc);
    crs_seen  = crs_i && !blinded;

    since_d = since_q;
    if (tx_active_i)
      since_d = '0;
    else if (since_q != CNT_MAX)
      since_d = since_q + 1'b1;

    idle_d = idle_q;
    if (tx_active_i || crs_seen)
      idle_d = '0;
    else if (idle_q != CNT_MAX)
      idle_d = idle_q + 1'b1;

    gap_ok = (({1'b0, idle_q} + {{CYC_W{1'b0}}, 1'b1}) >= {1'b0, ipg_cyc});
    cts_o  = gap_ok && !crs_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= CNT_MAX;
      idle_q  <= CNT_MAX;
    end else begin
      since_q <= since_d;
      idle_q  <= idle_d;
    end
  end

  // R4
  carrier_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_i && !blinded && !tx_active_i && ipg_cyc > 1) |=> (!cts_o || !$stable(ipg_len_i)));
endmodule

// File: rtl/mii_retry_count.sv
module mii_retry_count #(
  parameter int MAX_ATT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_hit_i,
  input  logic clear_i,
  output logic last_o
);
  localparam int ATT_W = $clog2(MAX_ATT + 1);

  logic [ATT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)
      cnt_d = '0;
    else if (col_hit_i)
      cnt_d = cnt_q + 1'b1;
    last_o = (cnt_q == ATT_W'(MAX_ATT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R8
  att_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ATT_W'(MAX_ATT));
endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_defer_pkg::*;
#(
  parameter int          NIB_W    = 4,
  parameter int          JAM_NIBS = 8,
  parameter logic [3:0]  JAM_PAT  = 4'h5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_avail_i,
  input  logic             cts_i,
  input  logic             col_i,
  input  logic [NIB_W-1:0] buf_nib_i,
  input  logic             buf_last_i,
  input  logic             backoff_done_i,
  input  logic             att_last_i,
  output logic             buf_rd_o,
  output logic [NIB_W-1:0] txd_o,
  output logic             tx_en_o,
  output logic             retry_o,
  output logic             done_o,
  output logic             excess_o,
  output logic             col_hit_o,
  output logic             att_clear_o
);
  localparam int JAM_W = $clog2(JAM_NIBS + 1);
  localparam logic [NIB_W-1:0] JAM_NIB = NIB_W'(JAM_PAT);

  tx_state_e        st_q, st_d;
  logic [NIB_W-1:0] txd_q, txd_d;
  logic             en_q, en_d;
  logic             last_q, last_d;
  logic [JAM_W-1:0] jam_q, jam_d;
  logic             retry_q, retry_d;
  logic             done_q, done_d;
  logic             excess_q, excess_d;

  always_comb begin
    st_d     = st_q;
    txd_d    = txd_q;
    en_d     = en_q;
    last_d   = last_q;
    jam_d    = jam_q;
    retry_d  = 1'b0;
    done_d   = 1'b0;
    excess_d = 1'b0;
    buf_rd_o  = 1'b0;
    col_hit_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_avail_i && cts_i) begin
          st_d     = ST_SEND;
          txd_d    = buf_nib_i;
          en_d     = 1'b1;
          last_d   = buf_last_i;
          buf_rd_o = 1'b1;
        end
      end
      ST_SEND: begin
        if (col_i) begin
          st_d      = ST_JAM;
          txd_d     = JAM_NIB;
          jam_d     = JAM_W'(1);
          col_hit_o = 1'b1;
        end else if (last_q) begin
          st_d   = ST_IDLE;
          txd_d  = '0;
          en_d   = 1'b0;
          done_d = 1'b1;
        end else begin
          txd_d    = buf_nib_i;
          last_d   = buf_last_i;
          buf_rd_o = 1'b1;
        end
      end
      ST_JAM: begin
        if (jam_q == JAM_W'(JAM_NIBS)) begin
          txd_d = '0;
          en_d  = 1'b0;
          if (att_last_i) begin
            st_d     = ST_IDLE;
            excess_d = 1'b1;
          end else begin
            st_d    = ST_WAIT;
            retry_d = 1'b1;
          end
        end else begin
          jam_d = jam_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (backoff_done_i)
          st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    att_clear_o = done_d || excess_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      txd_q    <= '0;
      en_q     <= 1'b0;
      last_q   <= 1'b0;
      jam_q    <= '0;
      retry_q  <= 1'b0;
      done_q   <= 1'b0;
      excess_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      txd_q    <= txd_d;
      en_q     <= en_d;
      last_q   <= last_d;
      jam_q    <= jam_d;
      retry_q  <= retry_d;
      done_q   <= done_d;
      excess_q <= excess_d;
    end
  end

  assign txd_o    = txd_q;
  assign tx_en_o  = en_q;
  assign retry_o  = retry_q;
  assign done_o   = done_q;
  assign excess_o = excess_q;

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(frame_avail_i && cts_i));
  // R5
  read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |=> (en_q && txd_q == $past(buf_nib_i)));
  // R6
  jam_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_JAM) |-> (en_q && txd_q == JAM_NIB && !buf_rd_o));
  // R7
  retry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> (!en_q && st_q == ST_WAIT));
  // R8
  excess_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excess_q |-> (!en_q && !retry_q && st_q == ST_IDLE));
  // R10
  backoff_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && col_i) |=> !en_q);
endmodule

// File: rtl/mii_tx_defer.sv
module mii_tx_defer #(
  parameter int         LEN_W    = 10,
  parameter int         MAX_ATT  = 16,
  parameter int         JAM_NIBS = 8,
  parameter logic [3:0] JAM_PAT  = 4'h5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_avail_i,
  input  logic [3:0]       buf_nib_i,
  input  logic             buf_last_i,
  output logic             buf_rd_o,
  input  logic             crs_i,
  input  logic             col_i,
  input  logic [LEN_W-1:0] blind_len_i,
  input  logic [LEN_W-1:0] ipg_len_i,
  input  logic             backoff_done_i,
  output logic [3:0]       txd_o,
  output logic             tx_en_o,
  output logic             retry_o,
  output logic             done_o,
  output logic             excess_col_o
);
  logic rst_meta_q, rst_sync_q;
  logic cts, att_last, col_hit, att_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mii_defer_timer #(.LEN_W(LEN_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .tx_active_i (tx_en_o),
    .crs_i       (crs_i),
    .blind_len_i (blind_len_i),
    .ipg_len_i   (ipg_len_i),
    .cts_o       (cts)
  );

  mii_retry_count #(.MAX_ATT(MAX_ATT)) u_retry (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .col_hit_i (col_hit),
    .clear_i   (att_clear),
    .last_o    (att_last)
  );

  mii_tx_seq #(.NIB_W(4), .JAM_NIBS(JAM_NIBS), .JAM_PAT(JAM_PAT)) u_seq (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .frame_avail_i  (frame_avail_i),
    .cts_i          (cts),
    .col_i          (col_i),
    .buf_nib_i      (buf_nib_i),
    .buf_last_i     (buf_last_i),
    .backoff_done_i (backoff_done_i),
    .att_last_i     (att_last),
    .buf_rd_o       (buf_rd_o),
    .txd_o          (txd_o),
    .tx_en_o        (tx_en_o),
    .retry_o        (retry_o),
    .done_o         (done_o),
    .excess_o       (excess_col_o),
    .col_hit_o      (col_hit),
    .att_clear_o    (att_clear)
  );
endmodule

// File: tb/test_mii_tx_defer.sv
module test_mii_tx_defer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_avail, crs, col, backoff_done;
  logic [9:0] blind_len, ipg_len;
  logic [3:0] buf_nib, txd;
  logic       buf_last, buf_rd, tx_en, retry, done, excess;

  int checks = 0;
  int fails  = 0;
  int seed = 0;
  int frame_len = 4;
  int rd_idx = 0;
  int reads = 0;
  int idle_run = 0;
  int last_gap = 0;
  logic [3:0] cap [64];
  int ncap;

  always #10 clk = ~clk;

  function automatic logic [3:0] exp_nib(int s, int i);
    return 4'((s + 7 * i) & 15);
  endfunction

  assign buf_nib  = exp_nib(seed, rd_idx);
  assign buf_last = (rd_idx == frame_len - 1);

  always @(posedge clk) begin
    if (retry || done || excess) rd_idx <= 0;
    else if (buf_rd) rd_idx <= rd_idx + 1;
    if (buf_rd) reads <= reads + 1;
  end

  always @(negedge clk) begin
    if (tx_en) begin
      if (idle_run > 0) last_gap <= idle_run;
      idle_run <= 0;
    end else begin
      idle_run <= idle_run + 1;
    end
  end

  mii_tx_defer i_mii_tx_defer (
    .clk(clk), .rst_n(rst_n), .frame_avail_i(frame_avail), .buf_nib_i(buf_nib),
    .buf_last_i(buf_last), .buf_rd_o(buf_rd), .crs_i(crs), .col_i(col),
    .blind_len_i(blind_len), .ipg_len_i(ipg_len), .backoff_done_i(backoff_done),
    .txd_o(txd), .tx_en_o(tx_en), .retry_o(retry), .done_o(done), .excess_col_o(excess)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_attempt(input int col_at);
    while (!tx_en) @(negedge clk);
    ncap = 0;
    while (tx_en) begin
      cap[ncap] = txd;
      ncap++;
      col = (ncap == col_at);
      @(negedge clk);
    end
    col = 1'b0;
  endtask

  task automatic data_ok(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] != exp_nib(seed, i)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic pulse_backoff();
    backoff_done = 1'b1;
    @(negedge clk);
    backoff_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    chk(!tx_en && txd == 4'h0, "R1 tx idle in reset", int'(tx_en), 0);
    chk(!buf_rd && !retry && !done && !excess, "R1 strobes low in reset", int'(buf_rd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tx_en && !buf_rd, "R1 quiet after reset release", int'(tx_en), 0);
  endtask

  task automatic t_single();
    int r0;
    seed = 3; frame_len = 10; frame_avail = 1'b1;
    r0 = reads;
    run_attempt(0);
    frame_avail = 1'b0;
    // R9 completion pulse
    chk(done && !retry && !excess, "R9 done pulse", int'(done), 1);
    // R5 length, order, reads
    chk(ncap == 10, "R5 nibble count", ncap, 10);
    data_ok(10, "R5 nibble order");
    chk(reads - r0 == 10, "R5 read strobes", reads - r0, 10);
  endtask

  task automatic t_gap();
    seed = 5; frame_len = 6; frame_avail = 1'b1;
    run_attempt(0);
    run_attempt(0);
    // R2 default 96 bit times -> 24 cycles
    chk(last_gap == 24, "R2 gap 96 bits", last_gap, 24);
    ipg_len = 10'd40;
    run_attempt(0);
    chk(last_gap == 10, "R2 short gap", last_gap, 10);
    ipg_len = 10'd200;
    run_attempt(0);
    chk(last_gap == 50, "R2 long gap", last_gap, 50);
    frame_avail = 1'b0;
    ipg_len = 10'd96;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_blind();
    seed = 11; frame_len = 5; frame_avail = 1'b1;
    run_attempt(0);
    @(negedge clk);
    crs = 1'b1;
    repeat (3) @(negedge clk);
    crs = 1'b0;
    run_attempt(0);
    // R4 carrier inside blinder ignored
    chk(last_gap == 24, "R4 blinded carrier", last_gap, 24);
    repeat (11) @(negedge clk);
    crs = 1'b1;
    repeat (3) @(negedge clk);
    crs = 1'b0;
    run_attempt(0);
    // R4 carrier after blinder restarts gap
    chk(last_gap == 38, "R4 carrier restart", last_gap, 38);
    frame_avail = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_idle();
    int hits = 0;
    frame_avail = 1'b0;
    for (int i = 0; i < 40; i++) begin
      col = (i % 5 == 0);
      crs = (i % 7 == 0);
      @(negedge clk);
      if (tx_en || buf_rd) hits++;
    end
    col = 1'b0; crs = 1'b0;
    // R3 no frame, no start; R10 collision ignored while idle
    chk(hits == 0, "R3 R10 idle without frame", hits, 0);
  endtask

  task automatic t_collide();
    int r0, jbad, hits;
    seed = 9; frame_len = 12; frame_avail = 1'b1;
    r0 = reads;
    run_attempt(5);
    // R7 retry pulse
    chk(retry && !done && !excess, "R7 retry pulse", int'(retry), 1);
    // R6 jam length and pattern
    chk(ncap == 13, "R6 data plus jam length", ncap, 13);
    data_ok(5, "R6 data before collision");
    jbad = 0;
    for (int i = 5; i < 13; i++) if (cap[i] != 4'h5) jbad++;
    chk(jbad == 0, "R6 jam pattern", jbad, 0);
    chk(reads - r0 == 5, "R6 no reads during jam", reads - r0, 5);
    hits = 0;
    for (int i = 0; i < 30; i++) begin
      col = (i == 4 || i == 17);
      @(negedge clk);
      if (tx_en || buf_rd) hits++;
    end
    col = 1'b0;
    // R7 waits for backoff, R10 collision ignored during wait
    chk(hits == 0, "R7 R10 silent in backoff", hits, 0);
    pulse_backoff();
    run_attempt(0);
    chk(ncap == 12 && done, "R7 full retry", ncap, 12);
    data_ok(12, "R7 retry from first nibble");
    frame_avail = 1'b0;
  endtask

  task automatic t_excess();
    int hits;
    seed = 1; frame_len = 6; frame_avail = 1'b1;
    for (int a = 1; a <= 16; a++) begin
      run_attempt(1);
      chk(ncap == 9, "R6 jam after first nibble", ncap, 9);
      if (a < 16) begin
        chk(retry && !excess, "R8 retry before limit", int'(excess), 0);
        repeat (3) @(negedge clk);
        pulse_backoff();
      end else begin
        frame_avail = 1'b0;
        // R8 sixteenth collision aborts
        chk(excess && !retry, "R8 excess on 16th", int'(excess), 1);
      end
    end
    hits = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_en) hits++;
    end
    chk(hits == 0, "R8 no backoff or resend after abort", hits, 0);
    seed = 2; frame_len = 7; frame_avail = 1'b1;
    run_attempt(2);
    // R9 count cleared: new frame gets retry not excess
    chk(retry && !excess, "R9 count cleared after abort", int'(excess), 0);
    pulse_backoff();
    run_attempt(0);
    chk(done && ncap == 7, "R9 done after one retry", ncap, 7);
    frame_avail = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    frame_avail = 1'b0; crs = 1'b0; col = 1'b0; backoff_done = 1'b0;
    blind_len = 10'd32; ipg_len = 10'd96;
    t_reset();
    t_single();
    t_gap();
    t_blind();
    t_idle();
    t_collide();
    t_excess();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule